// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block narrows an IEEE 754 binary32 word to a binary16 word and rounds to nearest with ties going to the even result. Every input class has a defined result. A NaN collapses to one quiet code. Infinities and magnitudes that do not fit saturate to infinity. Values too small for a binary16 normal are rounded onto the fixed subnormal grid of 2^-24, and may flush to a signed zero. Zeros and binary32 subnormals produce a signed zero.

A producer presents a word together with a valid strobe. The converted word appears with its own valid strobe. By default an output register adds one cycle of latency. With `REGISTER_OUT` set to 0 the path is purely combinational and the output valid follows the input valid in the same cycle.

Top module: `f32_to_f16_conv`

## Requirements
- R1: An input with exponent field 255 and a nonzero fraction gives output bits [14:0] = 0x7E00, with the input sign in bit 15.
- R2: For every input class, output bit 15 equals input bit 31.
- R3: An input with exponent field 255 and a zero fraction, or an input with exponent field 143 to 254, gives output bits [14:0] = 0x7C00.
- R4: An input with exponent field 0 gives output bits [14:0] = 0, so the result is a signed zero.
- R5: For an input exponent field e in the range 113 to 142, the output exponent field (bits [14:10]) is e-112 before rounding. The output fraction (bits [9:0]) is input fraction bits [22:13]. These bits round up when input bit 12 is set and either any of input bits [11:0] is set or input bit 13 is set.
- R6: The rounding increment is added to the packed exponent and fraction. A carry out of the fraction therefore raises the exponent by one. A carry that reaches exponent 31 gives exactly 0x7C00 (for example, input 0x477FF000 gives 0x7C00).
- R7: For an input exponent field of 1 to 112, the output is the input magnitude rounded to the nearest multiple of 2^-24 (ties to even), written as a subnormal code with exponent field 0. For example, 0x33000000 gives 0x0000, 0x33000001 gives 0x0001 and 0x33800000 gives 0x0001.
- R8: A subnormal result that rounds past 0x03FF becomes the smallest normal: input 0x387FE000 gives 0x0400.
- R9: With the output register present, both outputs are 0 during reset. After a clock edge that samples inValid high, outValid is 1 and outWord carries that input's result. After a clock edge that samples inValid low, outValid is 0.
- R10: With the output register present, outWord keeps its last value while inValid is low, whatever inWord does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks inWord as a word to convert |
| inWord | input | 32 | binary32 operand |
| outValid | output | 1 | Marks outWord as a fresh result |
| outWord | output | 16 | binary16 result |

## Verification
In the default registered build, each result and its valid strobe appear one clock edge after the edge that samples the input. The bench changes inputs at a falling edge and compares at the next falling edge, which falls exactly one capturing edge later. The check that inValid low gives outValid low also waits exactly one edge. The hold check changes inWord with inValid low and looks two falling edges later, after two capturing edges have passed without a load.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  // Format geometry
  localparam int SP_EXP_W   = 8;
  localparam int SP_FRAC_W  = 23;
  localparam int HP_EXP_W   = 5;
  localparam int HP_FRAC_W  = 10;

  localparam int SP_W       = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int HP_W       = 1 + HP_EXP_W + HP_FRAC_W;
  localparam int HP_MAG_W   = HP_W - 1;
  localparam int SIG_W      = SP_FRAC_W + 1;

  localparam int SP_BIAS    = (1 << (SP_EXP_W - 1)) - 1;
  localparam int HP_BIAS    = (1 << (HP_EXP_W - 1)) - 1;
  localparam int SP_EXP_ALL = (1 << SP_EXP_W) - 1;
  localparam int HP_EXP_ALL = (1 << HP_EXP_W) - 1;
  localparam int EXP_DELTA  = SP_BIAS - HP_BIAS;

  // Fraction bits dropped on the normal path
  localparam int DROP_W     = SP_FRAC_W - HP_FRAC_W;
  // Shift origin on the subnormal path: shift = SUB_ORIGIN - exponent
  localparam int SUB_ORIGIN = SP_BIAS - 1;
  // Shifts beyond this always give zero, so the shifter is capped here
  localparam int SHIFT_CAP  = HP_FRAC_W + DROP_W + 3;
  localparam int SHIFT_W    = $clog2(SHIFT_CAP + 1);
  localparam int WIDE_W     = SIG_W + SHIFT_CAP;
  localparam int SUB_LOW_W  = SHIFT_CAP + HP_FRAC_W;

  localparam logic [SP_EXP_W-1:0] EXP_TOP      = SP_EXP_W'(SP_EXP_ALL);
  localparam logic [SP_EXP_W-1:0] EXP_OVF_MIN  = SP_EXP_W'(EXP_DELTA + HP_EXP_ALL);
  localparam logic [SP_EXP_W-1:0] EXP_NORM_MIN = SP_EXP_W'(EXP_DELTA + 1);

  localparam logic [HP_MAG_W-1:0] MAG_INF  = HP_MAG_W'(HP_EXP_ALL << HP_FRAC_W);
  localparam logic [HP_MAG_W-1:0] MAG_QNAN = MAG_INF | HP_MAG_W'(1 << (HP_FRAC_W - 1));

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUB,
    CL_NORM,
    CL_OVF,
    CL_INF,
    CL_NAN
  } numClass_t;

  typedef struct packed {
    logic load;
  } ctrlStrobes_t;
endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
  import f2h_pkg::*;
(
  input  logic [SP_EXP_W-1:0]  expIn,
  input  logic [SP_FRAC_W-1:0] fracIn,
  output numClass_t            cls
);
  always_comb begin
    if (expIn == EXP_TOP)            cls = (|fracIn) ? CL_NAN : CL_INF;
    else if (expIn == '0)            cls = CL_ZERO;
    else if (expIn >= EXP_OVF_MIN)   cls = CL_OVF;
    else if (expIn >= EXP_NORM_MIN)  cls = CL_NORM;
    else                             cls = CL_SUB;
  end
endmodule

// File: rtl/f2h_rne.sv
module f2h_rne (
  input  logic keepLsb,
  input  logic guardBit,
  input  logic stickyBit,
  output logic roundUp
);
  // Above half: up. Exactly half: up only when the kept value is odd.
  assign roundUp = guardBit & (stickyBit | keepLsb);
endmodule

// File: rtl/f2h_ctrl.sv
module f2h_ctrl
  import f2h_pkg::*;
#(
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  assign strobes.load = inValid;

  generate
    if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) outValid <= 1'b0;
        else       outValid <= inValid;
      end
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/f2h_datapath.sv
module f2h_datapath
  import f2h_pkg::*;
#(
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [SP_W-1:0] inWord,
  output logic [HP_W-1:0] outWord
);
  logic                 signBit;
  logic [SP_EXP_W-1:0]  expIn;
  logic [SP_FRAC_W-1:0] fracIn;
  assign {signBit, expIn, fracIn} = inWord;

  numClass_t cls;
  f2h_classify u_classify (
    .expIn  (expIn),
    .fracIn (fracIn),
    .cls    (cls)
  );

  // Normal path: rebias the exponent, keep the top fraction bits
  logic [HP_EXP_W-1:0] normExp;
  logic [HP_MAG_W-1:0] normBase;
  logic                normGuard, normSticky;
  assign normExp    = HP_EXP_W'(expIn - SP_EXP_W'(EXP_DELTA));
  assign normBase   = {normExp, fracIn[SP_FRAC_W-1 -: HP_FRAC_W]};
  assign normGuard  = fracIn[DROP_W-1];
  assign normSticky = |fracIn[DROP_W-2:0];

  // Subnormal path: shift the full significand onto the 2^-24 grid
  logic [SP_EXP_W-1:0]  subDist;
  logic [SHIFT_W-1:0]   subShift;
  logic [WIDE_W-1:0]    sigExt;
  logic [SUB_LOW_W-1:0] subLow;
  logic [HP_MAG_W-1:0]  subBase;
  logic                 subGuard, subSticky;
  assign subDist   = SP_EXP_W'(SUB_ORIGIN) - expIn;
  assign subShift  = (subDist > SP_EXP_W'(SHIFT_CAP)) ? SHIFT_W'(SHIFT_CAP)
                                                      : subDist[SHIFT_W-1:0];
  assign sigExt    = {1'b1, fracIn, {SHIFT_CAP{1'b0}}};
  assign subLow    = SUB_LOW_W'(sigExt >> subShift);
  assign subBase   = {{HP_EXP_W{1'b0}}, subLow[SHIFT_CAP +: HP_FRAC_W]};
  assign subGuard  = subLow[SHIFT_CAP-1];
  assign subSticky = |subLow[SHIFT_CAP-2:0];

  // Shared rounding stage
  logic [HP_MAG_W-1:0] rndBase;
  logic                rndGuard, rndSticky, roundUp;
  always_comb begin
    if (cls == CL_NORM) begin
      rndBase   = normBase;
      rndGuard  = normGuard;
      rndSticky = normSticky;
    end else begin
      rndBase   = subBase;
      rndGuard  = subGuard;
      rndSticky = subSticky;
    end
  end

  f2h_rne u_rne (
    .keepLsb   (rndBase[0]),
    .guardBit  (rndGuard),
    .stickyBit (rndSticky),
    .roundUp   (roundUp)
  );

  // Exponent and fraction are added as one field so a carry moves up
  logic [HP_MAG_W-1:0] rndMag;
  assign rndMag = rndBase + HP_MAG_W'(roundUp);

  logic [HP_MAG_W-1:0] magOut;
  always_comb begin
    case (cls)
      CL_ZERO:         magOut = '0;
      CL_OVF, CL_INF:  magOut = MAG_INF;
      CL_NAN:          magOut = MAG_QNAN;
      default:         magOut = rndMag;
    endcase
  end

  logic [HP_W-1:0] combWord;
  assign combWord = {signBit, magOut};

  generate
    if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             outWord <= '0;
        else if (strobes.load) outWord <= combWord;
      end
    end else begin : g_comb
      assign outWord = combWord;
    end
  endgenerate
endmodule

// File: rtl/f32_to_f16_conv.sv
module f32_to_f16_conv
  import f2h_pkg::*;
#(
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inWord,
  output logic        outValid,
  output logic [15:0] outWord
);
  ctrlStrobes_t strobes;

  f2h_ctrl #(.REGISTER_OUT(REGISTER_OUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  f2h_datapath #(.REGISTER_OUT(REGISTER_OUT)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inWord  (inWord),
    .outWord (outWord)
  );
endmodule

// File: rtl/f32_to_f16_conv_chk.sv
module f32_to_f16_conv_chk
  import f2h_pkg::*;
#(
  parameter bit REGISTER_OUT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inWord,
  input logic        outValid,
  input logic [15:0] outWord
);
  localparam logic HOLD_ON = REGISTER_OUT;

  // Copy of the input aligned with the output timing
  logic        qValid;
  logic [31:0] qWord;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qValid <= 1'b0;
      qWord  <= '0;
    end else begin
      qValid <= inValid;
      qWord  <= inWord;
    end
  end

  logic        refValid;
  logic [31:0] refWord;
  assign refValid = REGISTER_OUT ? qValid : inValid;
  assign refWord  = REGISTER_OUT ? qWord  : inWord;

  logic [SP_EXP_W-1:0] refExp;
  logic                refNan, refOvf, refZero, refNorm;
  logic [HP_EXP_W-1:0] normExpRef;
  assign refExp     = refWord[30:23];
  assign refNan     = (refExp == EXP_TOP) && (refWord[22:0] != '0);
  assign refOvf     = (refExp >= EXP_OVF_MIN) && !refNan;
  assign refZero    = (refExp == '0);
  assign refNorm    = (refExp >= EXP_NORM_MIN) && (refExp < EXP_OVF_MIN);
  assign normExpRef = HP_EXP_W'(refExp - SP_EXP_W'(EXP_DELTA));

  a_r1_nan_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refNan) |-> (outWord == {refWord[31], MAG_QNAN}));

  a_r2_sign_copy: assert property (@(posedge clk) disable iff (!rstN)
    refValid |-> (outWord[15] == refWord[31]));

  a_r3_saturate_inf: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refOvf) |-> (outWord[14:0] == MAG_INF));

  a_r4_signed_zero: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refZero) |-> (outWord[14:0] == '0));

  // R5 and R6: exponent is rebiased, at most one higher after a carry
  a_r5_norm_exponent: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refNorm) |->
      ((outWord[14:10] == normExpRef) || (outWord[14:10] == normExpRef + 5'd1)));

  a_r9_valid_track: assert property (@(posedge clk) disable iff (!rstN)
    outValid == refValid);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (HOLD_ON && !inValid) |=> $stable(outWord));
endmodule

bind f32_to_f16_conv f32_to_f16_conv_chk #(.REGISTER_OUT(REGISTER_OUT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inWord   (inWord),
  .outValid (outValid),
  .outWord  (outWord)
);

// File: tb/f32_to_f16_conv_test.sv
module f32_to_f16_conv_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic [15:0] outWord;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  f32_to_f16_conv #(.REGISTER_OUT(1'b1)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inWord   (inWord),
    .outValid (outValid),
    .outWord  (outWord)
  );

  // Independent model: integer rounding of the significand to the output grid
  function automatic logic [15:0] refConv(input logic [31:0] w);
    logic   s;
    int     e, bigE, unitExp, drop;
    longint f, sig, q, rem, half;
    s = w[31];
    e = int'(w[30:23]);
    f = longint'(w[22:0]);
    if (e == 255) return (f != 0) ? {s, 15'h7E00} : {s, 15'h7C00};
    if (e == 0) return {s, 15'h0000};
    sig  = f + (longint'(1) << 23);
    bigE = e - 127;
    unitExp = (bigE < -14) ? -24 : bigE - 10;
    drop = unitExp - (bigE - 23);
    if (drop >= 26) return {s, 15'h0000};
    q    = sig >> drop;
    rem  = sig - (q << drop);
    half = longint'(1) << (drop - 1);
    if (rem > half || (rem == half && q[0])) q = q + 1;
    if (bigE < -14) return {s, 15'(q)};
    if (q == 2048) begin
      q = 1024;
      bigE = bigE + 1;
    end
    if (bigE > 15) return {s, 15'h7C00};
    return {s, 5'(bigE + 15), 10'(q - 1024)};
  endfunction

  function automatic string reqFor(input logic [31:0] w);
    if (w[30:23] == 8'd255) return (w[22:0] != 0) ? "R1" : "R3";
    if (w[30:23] == 8'd0)   return "R4";
    if (w[30:23] >= 8'd143) return "R3";
    if (w[30:23] >= 8'd113) return "R5";
    return "R7";
  endfunction

  function automatic logic [22:0] patOf(input int k);
    if (k < 23) return 23'(1) << k;
    case (k - 23)
      0: return 23'h000000;
      1: return 23'h7FFFFF;
      2: return 23'h001000;
      3: return 23'h003000;
      4: return 23'h001001;
      5: return 23'h7FE000;
      6: return 23'h7FF000;
      7: return 23'h400000;
      8: return 23'h2AAAAA;
      default: return 23'h555555;
    endcase
  endfunction

  task automatic check(input string req, input logic [16:0] act,
                       input logic [16:0] exp, input logic [31:0] stim);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s in=%h actual=%h expected=%h", req, stim, act, exp);
    end
  endtask

  // Drive at a falling edge; the result is due one rising edge later
  task automatic convOne(input logic [31:0] w, input string req, input logic [15:0] exp);
    @(negedge clk);
    inWord  = w;
    inValid = 1'b1;
    @(negedge clk);
    check(req, {outValid, outWord}, {1'b1, exp}, w);
    inValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", {outValid, outWord}, 17'h0, inWord);
    rstN = 1'b1;

    // Directed corner cases
    convOne(32'h3F800000, "R5", 16'h3C00);
    convOne(32'h3F801000, "R5", 16'h3C00);
    convOne(32'h3F803000, "R5", 16'h3C02);
    convOne(32'hBF800000, "R2", 16'hBC00);
    convOne(32'h7F800001, "R1", 16'h7E00);
    convOne(32'hFFC00000, "R1", 16'hFE00);
    convOne(32'h7F800000, "R3", 16'h7C00);
    convOne(32'h47800000, "R3", 16'h7C00);
    convOne(32'h477FE000, "R5", 16'h7BFF);
    convOne(32'h477FF000, "R6", 16'h7C00);
    convOne(32'h80000000, "R4", 16'h8000);
    convOne(32'h00400000, "R4", 16'h0000);
    convOne(32'h33800000, "R7", 16'h0001);
    convOne(32'h33000000, "R7", 16'h0000);
    convOne(32'h33000001, "R7", 16'h0001);
    convOne(32'h387FE000, "R8", 16'h0400);
    convOne(32'hB87FE000, "R8", 16'h8400);

    // R9: valid drops one edge after inValid drops
    @(negedge clk);
    check("R9", {16'h0, outValid}, 17'h0, inWord);

    // R10: changes on inWord with inValid low leave the output untouched
    convOne(32'h3F800000, "R5", 16'h3C00);
    @(negedge clk);
    inWord = 32'h7F800001;
    @(negedge clk);
    @(negedge clk);
    check("R10", {outValid, outWord}, {1'b0, 16'h3C00}, inWord);

    // Sweep every exponent with boundary fraction patterns, both signs
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 33; k++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] w;
          w = {1'(s), 8'(e), patOf(k)};
          convOne(w, reqFor(w), refConv(w));
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule